// File: doc/BRIEF.md
# SPI EEPROM Sequential Byte Reader

This block is a serial master that pulls a short run of bytes out of a small SPI serial EEPROM. A typical use is fetching a station address at boot. The host asks for a run with a one-cycle start pulse, a first byte address and a byte count. The block then issues one complete read transaction for each byte. The address goes up by one for each new byte. Each returned byte comes back on a data bus together with a one-cycle valid strobe.

A second mode reads the device status register. It sends the status instruction, skips the address phase and returns one byte. After reset the first request of either kind is preceded by a short wake preamble: two clock pulses with chip select held inactive. The serial clock is derived from the system clock. Each half period lasts `HALF_PERIOD` system cycles, and an idle gap of the same length separates consecutive transactions.

Top module: `eeprom_seq_reader`

## Requirements
- R1: Out of reset and whenever busy is low, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0, and done and byte_valid are 0.
- R2: Before the first transaction after reset, exactly two rising spi_sck edges occur with spi_cs_n high. Later requests add no further such edges.
- R3: A read transaction drives spi_cs_n low and shifts out the instruction 0x03 MSB first, then the 8-bit address MSB first. spi_mosi changes only while spi_sck is low, so it is stable at every rising edge. spi_cs_n is low only while busy is high.
- R4: After the address, eight data bits are taken from spi_miso, MSB first. Each bit is sampled in the low half of the clock that follows the falling edge on which the device presents it. The assembled byte appears on byte_data.
- R5: Every high pulse of spi_sck lasts exactly HALF_PERIOD system clock cycles.
- R6: A read request with count N performs N separate transactions at addresses A, A+1, ... modulo 256. Between consecutive transactions spi_cs_n stays high for at least HALF_PERIOD cycles.
- R7: byte_valid is high for exactly one cycle per returned byte. A read request produces exactly N pulses.
- R8: busy rises in the cycle after a start is accepted. done pulses once, after the final byte_valid, while busy is still high. busy falls in the next cycle.
- R9: A start pulse while busy is high is ignored. The running request's addresses, data and byte count are unchanged.
- R10: A read-mode start (op_status = 0) with byte_count = 0 is ignored. busy stays low and no serial activity occurs, not even the wake preamble.
- R11: With op_status = 1, a start sends the instruction 0x05 with no address phase. It then clocks in 8 status bits MSB first and returns exactly one byte, whatever start_addr and byte_count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| op_status | input | 1 | 0: data read run, 1: status register read |
| start_addr | input | 8 | Address of the first byte |
| byte_count | input | CNT_W | Number of bytes to fetch in read mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| byte_valid | output | 1 | One-cycle strobe qualifying byte_data |
| byte_data | output | 8 | Returned byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench builds the block with HALF_PERIOD = 3 and CNT_W = 4. An odd half period of more than one cycle catches an off-by-one in the clock divider. It also lets the gap after a transaction be told apart from a single-cycle gap. A 4-bit count allows runs of up to fifteen bytes, so starting addresses near 0xFF reach the address wrap. A behavioural device model answers on falling edges and decodes the instruction and address, so a misplaced capture point or a bit-order error shows up as a data miscompare.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 8;
    localparam int DATA_BITS  = 8;
    localparam int PH_W       = 6;
    localparam int BIT_W      = PH_W - 1;

    localparam logic [CMD_BITS-1:0] CMD_READ   = 8'h03;
    localparam logic [CMD_BITS-1:0] CMD_STATUS = 8'h05;

    // two full pulses: high, low, high, low
    localparam logic [PH_W-1:0] WAKE_LAST_PH = 6'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_XFER,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        OP_READ   = 1'b0,
        OP_STATUS = 1'b1
    } op_e;

    typedef struct packed {
        op_e                  op;
        logic [ADDR_BITS-1:0] addr;
    } xfer_s;

    // number of bit slots in one transaction
    function automatic logic [BIT_W-1:0] frame_bits(op_e op);
        if (op == OP_READ)
            return BIT_W'(CMD_BITS + ADDR_BITS + DATA_BITS);
        return BIT_W'(CMD_BITS + DATA_BITS);
    endfunction

    // index of the final half-clock phase of a transaction
    function automatic logic [PH_W-1:0] last_phase(op_e op);
        return {frame_bits(op), 1'b0} - 1'b1;
    endfunction

    // first bit slot in which the device returns data
    function automatic logic [BIT_W-1:0] data_first_bit(op_e op);
        if (op == OP_READ)
            return BIT_W'(CMD_BITS + ADDR_BITS);
        return BIT_W'(CMD_BITS);
    endfunction

    // serial-out value for a given bit slot
    function automatic logic tx_bit(op_e op, logic [ADDR_BITS-1:0] addr,
                                    logic [BIT_W-1:0] slot);
        logic [CMD_BITS-1:0] cmd;
        cmd = (op == OP_READ) ? CMD_READ : CMD_STATUS;
        if (slot < BIT_W'(CMD_BITS))
            return cmd[3'(BIT_W'(CMD_BITS - 1) - slot)];
        if (op == OP_READ && slot < BIT_W'(CMD_BITS + ADDR_BITS))
            return addr[3'(BIT_W'(CMD_BITS + ADDR_BITS - 1) - slot)];
        return 1'b0;
    endfunction

endpackage

// File: rtl/spif_tick.sv
module spif_tick #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spif_seq.sv
module spif_seq
    import spif_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 op_status,
    input  logic [ADDR_BITS-1:0] start_addr,
    input  logic [CNT_W-1:0]     byte_count,
    input  logic                 tick,
    output seq_state_e           state,
    output logic [PH_W-1:0]      ph,
    output xfer_s                xfer,
    output logic                 cap_en,
    output logic                 load_out,
    output logic                 active,
    output logic                 busy,
    output logic                 done
);
    logic [CNT_W-1:0] remaining;
    logic             woken;
    logic             accept;
    logic             last_ph;

    assign accept  = (state == ST_IDLE) && start &&
                     (op_status || (byte_count != '0));
    assign last_ph = (ph == last_phase(xfer.op));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ph        <= '0;
            xfer      <= '0;
            remaining <= '0;
            woken     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        xfer.op   <= op_status ? OP_STATUS : OP_READ;
                        xfer.addr <= start_addr;
                        remaining <= op_status ? CNT_W'(1) : byte_count;
                        ph        <= '0;
                        state     <= woken ? ST_XFER : ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (tick) begin
                        if (ph == WAKE_LAST_PH) begin
                            ph    <= '0;
                            woken <= 1'b1;
                            state <= ST_XFER;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        if (last_ph) begin
                            ph        <= '0;
                            remaining <= remaining - 1'b1;
                            state     <= ST_GAP;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (remaining == '0) begin
                            state <= ST_DONE;
                        end else begin
                            xfer.addr <= xfer.addr + 1'b1;
                            state     <= ST_XFER;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // capture at the end of a low half, once the data slots are reached
    assign cap_en   = (state == ST_XFER) && tick && !ph[0] &&
                      (ph[PH_W-1:1] >= data_first_bit(xfer.op));
    assign load_out = (state == ST_XFER) && tick && last_ph;
    assign active   = (state == ST_WAKE) || (state == ST_XFER) ||
                      (state == ST_GAP);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
endmodule

// File: rtl/spif_pins.sv
module spif_pins
    import spif_pkg::*;
(
    input  seq_state_e      state,
    input  logic [PH_W-1:0] ph,
    input  xfer_s           xfer,
    output logic            cs_n,
    output logic            sck,
    output logic            mosi
);
    always_comb begin
        cs_n = 1'b1;
        sck  = 1'b0;
        mosi = 1'b0;
        unique case (state)
            ST_WAKE: sck = !ph[0];
            ST_XFER: begin
                cs_n = 1'b0;
                sck  = ph[0];
                mosi = tx_bit(xfer.op, xfer.addr, ph[PH_W-1:1]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spif_rx.sv
module spif_rx
    import spif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 bit_in,
    input  logic                 load,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid
);
    logic [DATA_BITS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            if (shift_en)
                sr <= {sr[DATA_BITS-2:0], bit_in};
            if (load)
                data <= sr;
            valid <= load;
        end
    end
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
    import spif_pkg::*;
#(
    parameter int HALF_PERIOD = 4,
    parameter int CNT_W       = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 op_status,
    input  logic [ADDR_BITS-1:0] start_addr,
    input  logic [CNT_W-1:0]     byte_count,
    output logic                 busy,
    output logic                 done,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 spi_cs_n,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    input  logic                 spi_miso
);
    seq_state_e      state;
    logic [PH_W-1:0] ph;
    xfer_s           xfer;
    logic            tick;
    logic            active;
    logic            cap_en;
    logic            load_out;

    spif_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (active),
        .tick (tick)
    );

    spif_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_status  (op_status),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .tick       (tick),
        .state      (state),
        .ph         (ph),
        .xfer       (xfer),
        .cap_en     (cap_en),
        .load_out   (load_out),
        .active     (active),
        .busy       (busy),
        .done       (done)
    );

    spif_pins u_pins (
        .state (state),
        .ph    (ph),
        .xfer  (xfer),
        .cs_n  (spi_cs_n),
        .sck   (spi_sck),
        .mosi  (spi_mosi)
    );

    spif_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cap_en),
        .bit_in   (spi_miso),
        .load     (load_out),
        .data     (byte_data),
        .valid    (byte_valid)
    );
endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk #(
    parameter int HALF_PERIOD = 4
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic byte_valid,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '0;
        else if (spi_sck)
            hi_run <= hi_run + 1'b1;
        else
            hi_run <= '0;
    end

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs_n && !spi_sck && !spi_mosi && !done && !byte_valid));

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));

    // R3
    cs_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

    // R5
    sck_high_max_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> (hi_run < 16'(HALF_PERIOD)));

    // R5
    sck_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sck) |-> (hi_run == 16'(HALF_PERIOD)));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R8
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && !byte_valid));

    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy);
endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .byte_valid (byte_valid),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi)
);

// File: tb/eeprom_seq_reader_test.sv
module eeprom_seq_reader_test;
    localparam int HP    = 3;
    localparam int CNT_W = 4;
    localparam logic [7:0] STATUS_VAL = 8'hC6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             op_status = 1'b0;
    logic [7:0]       start_addr = '0;
    logic [CNT_W-1:0] byte_count = '0;
    logic             busy, done, byte_valid;
    logic [7:0]       byte_data;
    logic             spi_cs_n, spi_sck, spi_mosi;
    logic             spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    eeprom_seq_reader #(.HALF_PERIOD(HP), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .start(start), .op_status(op_status),
        .start_addr(start_addr), .byte_count(byte_count), .busy(busy),
        .done(done), .byte_valid(byte_valid), .byte_data(byte_data),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] mem_byte(input logic [7:0] a);
        return 8'(a * 8'd29 + 8'h5B) ^ {a[3:0], a[7:4]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // device model
    logic       m_sck = 1'b0, m_cs = 1'b1;
    int         bitc = 0;
    logic [7:0] cmd_sr = '0, addr_sr = '0, cur;
    int         wake_edges = 0, wake_at_first = -1, frames = 0;
    logic [7:0] exp_cmd = 8'h03, exp_addr = '0;
    int         exp_bits = 24;

    always @(spi_sck or spi_cs_n) begin
        if (!spi_cs_n && m_cs) begin
            if (frames == 0) wake_at_first = wake_edges;
            bitc = 0;
        end
        if (spi_sck && !m_sck) begin
            if (spi_cs_n) wake_edges++;
            else begin
                if (bitc < 8) cmd_sr = {cmd_sr[6:0], spi_mosi};
                else if (bitc < 16) addr_sr = {addr_sr[6:0], spi_mosi};
                bitc++;
            end
        end
        if (!spi_sck && m_sck && !spi_cs_n) begin
            if (cmd_sr == 8'h03 && bitc >= 16 && bitc < 24) begin
                cur = mem_byte(addr_sr);
                spi_miso = cur[23 - bitc];
            end else if (cmd_sr == 8'h05 && bitc >= 8 && bitc < 16) begin
                spi_miso = STATUS_VAL[15 - bitc];
            end else begin
                spi_miso = 1'b1;
            end
        end
        if (spi_cs_n && !m_cs) begin
            frames++;
            chk(cmd_sr == exp_cmd, "R3/R11 instruction", cmd_sr, exp_cmd);
            chk(bitc == exp_bits, "R3/R11 frame length", bitc, exp_bits);
            if (exp_cmd == 8'h03) begin
                chk(addr_sr == exp_addr, "R6 transaction address", addr_sr, exp_addr);
                exp_addr = exp_addr + 8'd1;
            end
            spi_miso = 1'b0;
        end
        m_sck = spi_sck;
        m_cs  = spi_cs_n;
    end

    // timing monitors
    int  sck_run = 0, sck_bad = 0, cs_hi = 0, gap_bad = 0;
    bit  had_frame = 0;
    always @(negedge clk) begin
        if (spi_sck) sck_run++;
        else begin
            if (sck_run != 0 && sck_run != HP) sck_bad++;
            sck_run = 0;
        end
        if (spi_cs_n) cs_hi++;
        else begin
            if (had_frame && cs_hi > 0 && cs_hi < HP) gap_bad++;
            cs_hi = 0;
            had_frame = 1;
        end
        if (!busy) had_frame = 0;
    end

    task automatic run_req(input bit op, input logic [7:0] addr,
                           input logic [CNT_W-1:0] cnt, input bit inject);
        int n_exp, got, cyc;
        bit prev_v, fin;
        n_exp    = op ? 1 : int'(cnt);
        exp_cmd  = op ? 8'h05 : 8'h03;
        exp_bits = op ? 16 : 24;
        exp_addr = addr;
        got = 0; cyc = 0; prev_v = 0; fin = 0;
        @(negedge clk);
        start = 1; op_status = op; start_addr = addr; byte_count = cnt;
        @(negedge clk);
        start = 0; start_addr = 8'h00; byte_count = '0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        while (!fin) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 40) begin
                start = 1; op_status = 0; start_addr = ~addr; byte_count = 4'd2;
            end else if (inject && cyc == 41) begin
                start = 0;
            end
            chk(!(byte_valid && prev_v), "R7 valid one cycle", 1, 0);
            if (byte_valid) begin
                if (op)
                    chk(byte_data == STATUS_VAL, "R11 status byte", byte_data, STATUS_VAL);
                else
                    chk(byte_data == mem_byte(addr + 8'(got)), "R4 read data",
                        byte_data, mem_byte(addr + 8'(got)));
                got++;
            end
            prev_v = byte_valid;
            if (done) begin
                fin = 1;
                chk(got == n_exp, inject ? "R9 count unchanged" : "R7/R8 bytes before done",
                    got, n_exp);
            end
        end
        @(negedge clk);
        chk(!busy && spi_cs_n && !spi_sck && !done, "R8 busy falls after done", busy, 0);
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int zero_busy;
        void'($urandom(32'd7741));
        repeat (4) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !spi_mosi && !busy && !done && !byte_valid,
            "R1 reset state", {spi_cs_n, spi_sck, spi_mosi, busy}, 4'b1000);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(spi_cs_n && !spi_sck && !busy, "R1 idle after reset", busy, 0);

        // R10: zero count read start is ignored
        start = 1; op_status = 0; start_addr = 8'h12; byte_count = '0;
        @(negedge clk);
        start = 0;
        zero_busy = 0;
        repeat (30) begin
            @(negedge clk);
            if (busy || !spi_cs_n || spi_sck) zero_busy++;
        end
        chk(zero_busy == 0, "R10 zero count ignored", zero_busy, 0);
        chk(wake_edges == 0, "R10 no wake on zero count", wake_edges, 0);

        // R2: first request carries the wake preamble
        run_req(0, 8'h00, 4'd1, 0);
        chk(wake_at_first == 2, "R2 wake before first frame", wake_at_first, 2);

        // R6: address wrap across 0xFF
        run_req(0, 8'hFE, 4'd4, 0);
        // R11: status read ignores count and address
        run_req(1, 8'h77, 4'd9, 0);
        // R9: start during busy ignored
        run_req(0, 8'h40, 4'd3, 1);
        // full-length run
        run_req(0, 8'hF3, 4'd15, 0);

        for (int i = 0; i < 25; i++) begin
            bit op;
            logic [CNT_W-1:0] c;
            op = ($urandom % 6) == 0;
            c  = CNT_W'(($urandom % 15) + 1);
            run_req(op, 8'($urandom), c, 0);
        end

        chk(wake_edges == 2, "R2 no later wake", wake_edges, 2);
        chk(sck_bad == 0, "R5 sck high width", sck_bad, 0);
        chk(gap_bad == 0, "R6 gap between frames", gap_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule